// File: doc/BRIEF.md
# Self-Steering Three-Level Omega Interconnect

This block connects eight requesters to eight targets through three levels of 2x2 exchange elements. Each level has four elements. A requester raises its request with a 3-bit target index. Each level steers the request with one bit of that index, and the levels consume the bits from the most significant to the least significant. Between the levels the lines are rewired by a perfect shuffle, which rotates the 3-bit line index left by one. This wiring lets any requester reach any target. Arbitration, the grant and the refusal all resolve in the same cycle as the request.

When two requests meet at one element output, the request on the element's upper input (line index LSB 0) wins. The other request is refused and must try again later. A granted requester that also raises its hold signal locks every element output on its path at the next rising clock edge. The locked path then carries the later beats of the transfer: the address, then write data forward or read data back. The source, write flag and payload go forward to the target. The target's return data goes back to the requester. The path is freed at the first rising edge at which the requester's hold (or request) is seen low.

Top module: `omega_net`

## Requirements
- R1: While reset is high, and at the first edge after it, every lock is cleared. A request made after reset is not refused by a path that was held before reset.
- R2: A request with no competition is granted in the same cycle and arrives at target `src_dest`. That target shows `dst_valid` high and `dst_src` equal to the requester index. Exactly one target is valid.
- R3: Level k (k = 0, 1, 2) steers by target bit 2-k. Bit 0 selects the element's upper output (line LSB 0) and bit 1 selects the lower output. Before each level, line i moves to line rotl3(i).
- R4: When two fresh requests want the same element output, the one that entered on the upper input (line LSB 0) is granted. The other sees `src_blocked` high in the same cycle.
- R5: `src_grant` and `src_blocked` are never high together, and neither is high without `src_req`.
- R6: A request granted with `src_hold` high locks its path at the next rising edge. While the path is held, the requester stays granted to the original target even if `src_dest` changes.
- R7: A locked element output refuses every other request for it, including one that would win by priority.
- R8: A lock ends at the first rising edge at which the holder's hold or request is low. It is still in force during the cycle in which hold drops.
- R9: `src_rdata` of a granted requester equals the `dst_rdata` of the target it reaches, in the same cycle. It is zero for a requester that is not granted.
- R10: `dst_write` and `dst_wdata` at the target equal the granted requester's `src_write` and `src_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 8 | Request, one bit per requester |
| src_hold | input | 8 | Keep the granted path locked for further beats |
| src_dest | input | 8x3 | Target index per requester |
| src_write | input | 8 | Transfer direction per requester, 1 = write |
| src_wdata | input | 8x8 | Forward payload per requester |
| src_grant | output | 8 | Path complete this cycle |
| src_blocked | output | 8 | Request refused this cycle, retry |
| src_rdata | output | 8x8 | Return data from the reached target |
| dst_valid | output | 8 | A path ends at this target |
| dst_src | output | 8x3 | Index of the requester reaching this target |
| dst_write | output | 8 | Direction forwarded to the target |
| dst_wdata | output | 8x8 | Payload forwarded to the target |
| dst_rdata | input | 8x8 | Return data from each target |

## Verification
Grant, refusal, arrival, forwarded payload and return data all follow the inputs in the same cycle, through combinational logic. The bench therefore drives inputs just after a falling edge and samples 1 ns later, within that cycle. Locks take effect only at the next rising edge. Each hold and release check is made in the half-cycle after that edge: the lock must be present in the cycle after a held grant, still present in the cycle in which hold drops, and gone one edge later. Expected winners come from a bench-side model of the line index after each level.

// File: rtl/omega_pkg.sv
package omega_pkg;
    localparam int AW = 3;
    localparam int NL = 1 << AW;
    localparam int DW = 8;

    typedef logic [AW-1:0] idx_t;
    typedef logic [DW-1:0] data_t;

    typedef struct packed {
        logic  active;
        logic  hold;
        logic  write;
        idx_t  src;
        idx_t  dest;
        data_t data;
    } line_t;

    function automatic idx_t shuffle(idx_t i);
        return {i[AW-2:0], i[AW-1]};
    endfunction
endpackage

// File: rtl/omega_switch.sv
module omega_switch
    import omega_pkg::*;
#(
    parameter int BIT = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  line_t [1:0]      in_line,
    output line_t [1:0]      out_line,
    input  logic  [1:0]      out_ok,
    output logic  [1:0]      in_ok,
    input  data_t [1:0]      out_ret,
    output data_t [1:0]      in_ret
);
    logic [1:0] lock_v, lock_sel;
    logic [1:0] lock_v_n, lock_sel_n;
    logic [1:0] conn, sel, busy;

    always_comb begin
        busy = '0;
        for (int o = 0; o < 2; o++)
            if (lock_v[o]) busy[lock_sel[o]] = 1'b1;
        for (int o = 0; o < 2; o++) begin
            conn[o] = 1'b0;
            sel[o]  = 1'b0;
            if (lock_v[o]) begin
                conn[o] = 1'b1;
                sel[o]  = lock_sel[o];
            end else if (in_line[0].active && !busy[0] && in_line[0].dest[BIT] == o[0]) begin
                conn[o] = 1'b1;
                sel[o]  = 1'b0;
            end else if (in_line[1].active && !busy[1] && in_line[1].dest[BIT] == o[0]) begin
                conn[o] = 1'b1;
                sel[o]  = 1'b1;
            end
            out_line[o] = conn[o] ? in_line[sel[o]] : '0;
        end
        in_ok  = '0;
        in_ret = '0;
        for (int o = 0; o < 2; o++)
            if (conn[o]) begin
                in_ok[sel[o]]  = out_ok[o];
                in_ret[sel[o]] = out_ret[o];
            end
        for (int o = 0; o < 2; o++) begin
            lock_v_n[o]   = conn[o] && out_line[o].active && out_line[o].hold && out_ok[o];
            lock_sel_n[o] = sel[o];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_v   <= '0;
            lock_sel <= '0;
        end else begin
            lock_v   <= lock_v_n;
            lock_sel <= lock_sel_n;
        end
    end

    // R7: two locks in one element never share an input
    a_r7_locks_distinct: assert property (@(posedge clk) disable iff (rst)
        (lock_v == 2'b11) |-> (lock_sel[0] != lock_sel[1]));

    for (genvar o = 0; o < 2; o++) begin : g_chk
        // R8: a lock whose carried line shows no hold is gone after the edge
        a_r8_release: assert property (@(posedge clk) disable iff (rst)
            (lock_v[o] && !out_line[o].hold) |=> !lock_v[o]);
        // R1: no lock survives a reset edge
        a_r1_reset_clears: assert property (@(posedge clk)
            $past(rst) |-> !lock_v[o]);
    end
endmodule

// File: rtl/omega_stage.sv
module omega_stage
    import omega_pkg::*;
#(
    parameter int LEVEL = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  line_t [NL-1:0]    in_line,
    output line_t [NL-1:0]    out_line,
    input  logic  [NL-1:0]    out_ok,
    output logic  [NL-1:0]    in_ok,
    input  data_t [NL-1:0]    out_ret,
    output data_t [NL-1:0]    in_ret
);
    localparam int BIT = AW - 1 - LEVEL;

    line_t [NL-1:0] sw_in;
    logic  [NL-1:0] sw_ok;
    data_t [NL-1:0] sw_ret;

    always_comb begin
        for (int j = 0; j < NL; j++) begin
            sw_in[shuffle(idx_t'(j))] = in_line[j];
            in_ok[j]  = sw_ok[shuffle(idx_t'(j))];
            in_ret[j] = sw_ret[shuffle(idx_t'(j))];
        end
    end

    for (genvar k = 0; k < NL / 2; k++) begin : g_sw
        omega_switch #(.BIT(BIT)) u_sw (
            .clk     (clk),
            .rst     (rst),
            .in_line (sw_in[2*k+1:2*k]),
            .out_line(out_line[2*k+1:2*k]),
            .out_ok  (out_ok[2*k+1:2*k]),
            .in_ok   (sw_ok[2*k+1:2*k]),
            .out_ret (out_ret[2*k+1:2*k]),
            .in_ret  (sw_ret[2*k+1:2*k])
        );
    end
endmodule

// File: rtl/omega_net.sv
module omega_net
    import omega_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NL-1:0]         src_req,
    input  logic [NL-1:0]         src_hold,
    input  logic [NL-1:0][AW-1:0] src_dest,
    input  logic [NL-1:0]         src_write,
    input  logic [NL-1:0][DW-1:0] src_wdata,
    output logic [NL-1:0]         src_grant,
    output logic [NL-1:0]         src_blocked,
    output logic [NL-1:0][DW-1:0] src_rdata,
    output logic [NL-1:0]         dst_valid,
    output logic [NL-1:0][AW-1:0] dst_src,
    output logic [NL-1:0]         dst_write,
    output logic [NL-1:0][DW-1:0] dst_wdata,
    input  logic [NL-1:0][DW-1:0] dst_rdata
);
    line_t [NL-1:0] lines [0:AW];
    logic  [NL-1:0] ok    [0:AW];
    data_t [NL-1:0] ret   [0:AW];

    always_comb begin
        for (int s = 0; s < NL; s++) begin
            lines[0][s].active = src_req[s];
            lines[0][s].hold   = src_hold[s];
            lines[0][s].write  = src_write[s];
            lines[0][s].src    = idx_t'(s);
            lines[0][s].dest   = src_dest[s];
            lines[0][s].data   = src_wdata[s];
        end
    end

    for (genvar g = 0; g < AW; g++) begin : g_lvl
        omega_stage #(.LEVEL(g)) u_stage (
            .clk     (clk),
            .rst     (rst),
            .in_line (lines[g]),
            .out_line(lines[g+1]),
            .out_ok  (ok[g+1]),
            .in_ok   (ok[g]),
            .out_ret (ret[g+1]),
            .in_ret  (ret[g])
        );
    end

    for (genvar d = 0; d < NL; d++) begin : g_dst
        assign ok[AW][d]    = lines[AW][d].active;
        assign ret[AW][d]   = dst_rdata[d];
        assign dst_valid[d] = lines[AW][d].active;
        assign dst_src[d]   = lines[AW][d].src;
        assign dst_write[d] = lines[AW][d].write;
        assign dst_wdata[d] = lines[AW][d].data;
    end

    for (genvar s = 0; s < NL; s++) begin : g_src
        assign src_grant[s]   = src_req[s] & ok[0][s];
        assign src_blocked[s] = src_req[s] & ~ok[0][s];
        assign src_rdata[s]   = src_grant[s] ? ret[0][s] : '0;

        // R2: a fresh grant reaches the addressed target
        a_r2_route: assert property (@(posedge clk) disable iff (rst)
            (src_grant[s] && !$past(src_grant[s] && src_hold[s]))
            |-> (dst_valid[src_dest[s]] && dst_src[src_dest[s]] == idx_t'(s)));
        // R6: a path granted with hold stays granted next cycle
        a_r6_held_granted: assert property (@(posedge clk) disable iff (rst)
            ($past(src_grant[s] && src_hold[s] && !rst) && src_req[s]) |-> src_grant[s]);
    end

    for (genvar d = 0; d < NL; d++) begin : g_dchk
        // R5: every arrival belongs to a granted requester
        a_r5_arrival_granted: assert property (@(posedge clk) disable iff (rst)
            dst_valid[d] |-> src_grant[dst_src[d]]);
    end
endmodule

// File: tb/omega_net_bench.sv
module omega_net_bench;
    import omega_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [NL-1:0]         src_req, src_hold, src_write;
    logic [NL-1:0][AW-1:0] src_dest;
    logic [NL-1:0][DW-1:0] src_wdata;
    logic [NL-1:0]         src_grant, src_blocked;
    logic [NL-1:0][DW-1:0] src_rdata;
    logic [NL-1:0]         dst_valid, dst_write;
    logic [NL-1:0][AW-1:0] dst_src;
    logic [NL-1:0][DW-1:0] dst_wdata;
    logic [NL-1:0][DW-1:0] dst_rdata;

    omega_net u_omega_net (.*);

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit good, input string req, input int act, input int exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rotl(int l);
        return ((l << 1) | (l >> (AW - 1))) & (NL - 1);
    endfunction

    // R3: line after level k
    function automatic int line_after(int s, int d, int k);
        int l = s;
        for (int i = 0; i <= k; i++) begin
            l = rotl(l);
            l = (l & ~1) | ((d >> (AW - 1 - i)) & 1);
        end
        return l;
    endfunction

    function automatic int port_at(int s, int d, int k);
        int l = (k == 0) ? s : line_after(s, d, k - 1);
        return rotl(l) & 1;
    endfunction

    // winner index, or -1 when the two paths never share an output
    function automatic int winner(int a, int da, int b, int db);
        for (int k = 0; k < AW; k++)
            if (line_after(a, da, k) == line_after(b, db, k))
                return (port_at(a, da, k) == 0) ? a : b;
        return -1;
    endfunction

    task automatic clear_in();
        src_req = '0; src_hold = '0; src_write = '0;
        src_dest = '0; src_wdata = '0;
    endtask

    task automatic drive(int s, int d, bit hold);
        src_req[s]   = 1'b1;
        src_hold[s]  = hold;
        src_dest[s]  = AW'(d);
        src_write[s] = s[0];
        src_wdata[s] = DW'(s * 16 + d);
    endtask

    task automatic expect_arrive(int s, int d, string req);
        chk(src_grant[s] && !src_blocked[s], req, src_grant[s], 1);
        chk(dst_valid[d] && dst_src[d] == AW'(s), req, int'(dst_src[d]), s);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int w, l, dw, dl;
        int first_w, first_l, first_dw, first_dl;
        bit found;
        for (int d = 0; d < NL; d++) dst_rdata[d] = DW'(8'h80 | d);
        clear_in();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;
        // R1: idle after reset
        chk(dst_valid == '0 && src_grant == '0 && src_blocked == '0, "R1 idle",
            int'(dst_valid), 0);

        // single requests, every source and target
        for (int s = 0; s < NL; s++)
            for (int d = 0; d < NL; d++) begin
                @(negedge clk); clear_in(); drive(s, d, 1'b0); #1;
                expect_arrive(s, d, "R2 single");
                chk($countones(dst_valid) == 1, "R2 one target", $countones(dst_valid), 1);
                chk(dst_write[d] == s[0] && dst_wdata[d] == DW'(s * 16 + d), "R10 payload",
                    int'(dst_wdata[d]), s * 16 + d);
                chk(src_rdata[s] == DW'(8'h80 | d), "R9 return", int'(src_rdata[s]), 8'h80 | d);
                chk(src_blocked == '0, "R5 no refusal", int'(src_blocked), 0);
            end

        // pairs of fresh requests
        found = 0;
        first_w = 0; first_l = 0; first_dw = 0; first_dl = 0;
        for (int a = 0; a < NL; a++)
            for (int b = a + 1; b < NL; b++)
                for (int da = 0; da < NL; da++)
                    for (int db = 0; db < NL; db++) begin
                        @(negedge clk); clear_in(); drive(a, da, 1'b0); drive(b, db, 1'b0); #1;
                        w = winner(a, da, b, db);
                        if (w < 0) begin
                            expect_arrive(a, da, "R3 disjoint");
                            expect_arrive(b, db, "R3 disjoint");
                        end else begin
                            l  = (w == a) ? b : a;
                            dw = (w == a) ? da : db;
                            dl = (w == a) ? db : da;
                            expect_arrive(w, dw, "R4 winner");
                            chk(src_blocked[l] && !src_grant[l], "R4 loser blocked",
                                src_blocked[l], 1);
                            chk(src_rdata[l] == '0, "R9 zero when refused", int'(src_rdata[l]), 0);
                            if (!found) begin
                                found = 1; first_w = w; first_l = l; first_dw = dw; first_dl = dl;
                            end
                        end
                    end

        // held paths against a priority winner
        for (int a = 0; a < NL; a++)
            for (int b = a + 1; b < NL; b++)
                for (int da = 0; da < NL; da += 3)
                    for (int db = 0; db < NL; db++) begin
                        w = winner(a, da, b, db);
                        if (w >= 0) begin
                            l  = (w == a) ? b : a;
                            dw = (w == a) ? da : db;
                            dl = (w == a) ? db : da;
                            @(negedge clk); clear_in(); drive(l, dl, 1'b1); #1;
                            chk(src_grant[l], "R6 hold grant", src_grant[l], 1);
                            @(negedge clk); drive(l, dl ^ (NL - 1), 1'b1); drive(w, dw, 1'b0); #1;
                            chk(src_blocked[w], "R7 held output refuses", src_blocked[w], 1);
                            expect_arrive(l, dl, "R6 held path ignores dest");
                            @(negedge clk); src_hold[l] = 1'b0; #1;
                            chk(src_blocked[w], "R8 lock kept while hold drops", src_blocked[w], 1);
                            @(negedge clk); src_req[l] = 1'b0; #1;
                            expect_arrive(w, dw, "R8 released");
                            @(negedge clk); clear_in();
                        end
                    end

        // reset clears a held path
        @(negedge clk); clear_in(); drive(first_l, first_dl, 1'b1); #1;
        chk(src_grant[first_l], "R1 setup hold", src_grant[first_l], 1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; clear_in(); #1;
        chk(dst_valid == '0, "R1 idle after reset", int'(dst_valid), 0);
        @(negedge clk); drive(first_l, first_dl ^ (NL - 1), 1'b1); drive(first_w, first_dw, 1'b0); #1;
        expect_arrive(first_w, first_dw, "R1 no stale lock");

        @(negedge clk); clear_in();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule